// File: doc/BRIEF.md
# Register Bank with Peripheral Window

This block is the 16-location, 8-bit register bank of a small processor. It has two read ports that answer within the same cycle and one write port that takes effect on the clock edge. The lower eight locations are ordinary registers held inside the bank. The upper eight locations hold no storage. They are a pass-through window onto peripheral registers that sit outside the bank.

For the window, the bank sends both read addresses, the write address, the write data and a write strobe out on a peripheral bus. It then selects the peripheral read-data lanes back onto its own read ports. The bank does not decode which peripheral owns a window address. Each attached peripheral recognises its own addresses on the bus and must serve two reads and one write in the same cycle.

The most significant address bit selects the half: 0 means internal storage and 1 means the window. There is no bypass from the write port to the read ports.

Top module: `regbank_pwin`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, and right after it is released, every internal location (addresses 0 to 7) reads as zero.
- R2: With wr_en high and wr_addr below 8, the addressed internal location takes wr_data on the rising clock edge, and the new value is visible on either read port from the following cycle.
- R3: A write to addresses 0 to 7 is not forwarded. per_wr_stb stays low for it.
- R4: With wr_en high and wr_addr of 8 or more, per_wr_stb is high in that same cycle, per_wr_addr equals wr_addr, per_wr_data equals wr_data, and no internal location changes.
- R5: Read port A returns the internal location for rd_a_addr below 8 and returns per_rd_a_data for rd_a_addr of 8 or more.
- R6: Read port B follows the same rule with rd_b_addr and per_rd_b_data, independently of port A and in the same cycle.
- R7: Reading an internal location in the cycle it is written returns its previous value.
- R8: per_rd_a_addr and per_rd_b_addr always equal rd_a_addr and rd_b_addr. per_wr_addr and per_wr_data always equal wr_addr and wr_data.
- R9: With wr_en low, no internal location changes and per_wr_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the internal locations |
| rd_a_addr | input | 4 | Read port A address |
| rd_a_data | output | 8 | Read port A data, combinational |
| rd_b_addr | input | 4 | Read port B address |
| rd_b_data | output | 8 | Read port B data, combinational |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| per_rd_a_addr | output | 4 | Read address A forwarded to peripherals |
| per_rd_a_data | input | 8 | Peripheral answer for read address A |
| per_rd_b_addr | output | 4 | Read address B forwarded to peripherals |
| per_rd_b_data | input | 8 | Peripheral answer for read address B |
| per_wr_addr | output | 4 | Write address forwarded to peripherals |
| per_wr_data | output | 8 | Write data forwarded to peripherals |
| per_wr_stb | output | 1 | Write strobe, high only for window writes |

## Verification
The assertions assume the peripheral read lanes are settled wherever the bank samples them. They also assume that wr_en, wr_addr and wr_data are known values whenever reset is released. The stimulus meets these assumptions by changing every input only on the falling clock edge and by driving per_rd_a_data and per_rd_b_data as plain random bytes. No address value or write pattern is excluded. Random traffic covers both halves on all three ports, and directed steps add the read-during-write collision, back-to-back writes to one location and a reset in the middle of the run.

// File: rtl/regbank_pwin_pkg.sv
package regbank_pwin_pkg;
  localparam int RB_DATA_W = 8;
  localparam int RB_ADDR_W = 4;

  // A window address has its top bit set; the lower half is internal storage.
  function automatic logic hits_window(input logic [RB_ADDR_W-1:0] a);
    return a[RB_ADDR_W-1];
  endfunction

  function automatic logic [RB_ADDR_W-2:0] local_index(input logic [RB_ADDR_W-1:0] a);
    return a[RB_ADDR_W-2:0];
  endfunction
endpackage

// File: rtl/rb_core_store.sv
module rb_core_store #(
  parameter int DATA_W  = 8,
  parameter int LOCAL_N = 8,
  localparam int IDX_W  = $clog2(LOCAL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);
  logic [LOCAL_N-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem <= '0;
    else if (we) mem[waddr] <= wdata;
  end

  // No bypass: reads see the contents before this cycle's write.
  assign q_a = mem[raddr_a];
  assign q_b = mem[raddr_b];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/rb_write_steer.sv
module rb_write_steer
  import regbank_pwin_pkg::*;
#(
  parameter int DATA_W = RB_DATA_W,
  parameter int ADDR_W = RB_ADDR_W,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              local_we,
  output logic [IDX_W-1:0]  local_idx,
  output logic              per_stb,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_data
);
  logic to_window;

  assign to_window = wr_addr[ADDR_W-1];
  assign local_we  = wr_en && !to_window;
  assign local_idx = wr_addr[IDX_W-1:0];
  assign per_stb   = wr_en && to_window;
  assign per_addr  = wr_addr;
  assign per_data  = wr_data;
endmodule

// File: rtl/rb_read_sel.sv
module rb_read_sel
  import regbank_pwin_pkg::*;
#(
  parameter int DATA_W = RB_DATA_W,
  parameter int ADDR_W = RB_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] local_q,
  input  logic [DATA_W-1:0] per_q,
  output logic [DATA_W-1:0] q
);
  always_comb begin
    if (addr[ADDR_W-1]) q = per_q;
    else                q = local_q;
  end
endmodule

// File: rtl/regbank_pwin.sv
module regbank_pwin
  import regbank_pwin_pkg::*;
#(
  parameter int DATA_W = RB_DATA_W,
  parameter int ADDR_W = RB_ADDR_W,
  localparam int LOCAL_N = 2 ** (ADDR_W - 1),
  localparam int IDX_W   = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] per_rd_a_addr,
  input  logic [DATA_W-1:0] per_rd_a_data,
  output logic [ADDR_W-1:0] per_rd_b_addr,
  input  logic [DATA_W-1:0] per_rd_b_data,
  output logic [ADDR_W-1:0] per_wr_addr,
  output logic [DATA_W-1:0] per_wr_data,
  output logic              per_wr_stb
);
  logic              local_we;
  logic [IDX_W-1:0]  local_idx;
  logic [DATA_W-1:0] store_q [2];
  logic [ADDR_W-1:0] port_addr [2];
  logic [DATA_W-1:0] port_per [2];
  logic [DATA_W-1:0] port_q [2];

  assign port_addr[0] = rd_a_addr;
  assign port_addr[1] = rd_b_addr;
  assign port_per[0]  = per_rd_a_data;
  assign port_per[1]  = per_rd_b_data;
  assign rd_a_data    = port_q[0];
  assign rd_b_data    = port_q[1];

  // Read addresses go out unchanged; peripherals decode them.
  assign per_rd_a_addr = rd_a_addr;
  assign per_rd_b_addr = rd_b_addr;

  rb_write_steer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_steer (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .local_we (local_we),
    .local_idx(local_idx),
    .per_stb  (per_wr_stb),
    .per_addr (per_wr_addr),
    .per_data (per_wr_data)
  );

  rb_core_store #(.DATA_W(DATA_W), .LOCAL_N(LOCAL_N)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (local_we),
    .waddr  (local_idx),
    .wdata  (wr_data),
    .raddr_a(rd_a_addr[IDX_W-1:0]),
    .raddr_b(rd_b_addr[IDX_W-1:0]),
    .q_a    (store_q[0]),
    .q_b    (store_q[1])
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    rb_read_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
      .addr   (port_addr[p]),
      .local_q(store_q[p]),
      .per_q  (port_per[p]),
      .q      (port_q[p])
    );
  end

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(local_we && per_wr_stb));

  assert_no_low_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_stb |-> wr_addr[ADDR_W-1]);

  assert_window_read_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_addr[ADDR_W-1] |-> (rd_a_data == per_rd_a_data));

  assert_window_read_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_addr[ADDR_W-1] |-> (rd_b_data == per_rd_b_data));
endmodule

// File: tb/test_regbank_pwin.sv
module test_regbank_pwin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0, per_rd_a_data = '0, per_rd_b_data = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rd_a_data, rd_b_data, per_wr_data;
  logic [3:0] per_rd_a_addr, per_rd_b_addr, per_wr_addr;
  logic       per_wr_stb;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  always #4 clk = ~clk;

  regbank_pwin i_regbank_pwin (.*);

  function automatic logic [7:0] expect_read(input logic [3:0] a, input logic [7:0] lane);
    if (a >= 4'd8) return lane;
    return model[a[2:0]];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_ports(input string tag);
    logic [7:0] ea, eb;
    ea = expect_read(rd_a_addr, per_rd_a_data);
    eb = expect_read(rd_b_addr, per_rd_b_data);
    chk(rd_a_data === ea, {tag, " R5 port A"}, rd_a_data, ea);
    chk(rd_b_data === eb, {tag, " R6 port B"}, rd_b_data, eb);
    chk(per_wr_stb === (wr_en && wr_addr >= 4'd8), {tag, " R3/R4 strobe"}, per_wr_stb,
        wr_en && wr_addr >= 4'd8);
    chk(per_rd_a_addr === rd_a_addr && per_rd_b_addr === rd_b_addr &&
        per_wr_addr === wr_addr && per_wr_data === wr_data, {tag, " R8 forward"},
        {per_rd_a_addr, per_rd_b_addr}, {rd_a_addr, rd_b_addr});
  endtask

  // One cycle: drive at falling edge, check mid-low phase, commit model at rising edge.
  task automatic step(input logic en, input logic [3:0] wa, input logic [7:0] wd,
                      input logic [3:0] ra, input logic [3:0] rb, input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
    per_rd_a_data = 8'($urandom); per_rd_b_data = 8'($urandom);
    #2;
    check_ports(tag);
    @(posedge clk);
    if (en && wa < 4'd8) model[wa[2:0]] = wd;
  endtask

  task automatic check_all_zero(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_a_addr = 4'(i); rd_b_addr = 4'(7 - i);
      #2;
      chk(rd_a_data === 8'h00 && rd_b_data === 8'h00, {tag, " R1 cleared"},
          {rd_a_data, rd_b_data}, 0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    check_all_zero("reset held");
    @(negedge clk) rst_n = 1'b1;
    check_all_zero("after release");

    // R2/R7: write 3 while both ports read it: old value now, new value next cycle.
    step(1'b1, 4'd3, 8'hA5, 4'd3, 4'd3, "R7 collision");
    step(1'b0, 4'd0, 8'h00, 4'd3, 4'd3, "R2 lands");
    step(1'b1, 4'd3, 8'h5A, 4'd3, 4'd11, "R7 back-to-back");
    step(1'b1, 4'd3, 8'hC3, 4'd3, 4'd3, "R2 back-to-back");
    step(1'b0, 4'd0, 8'h00, 4'd3, 4'd3, "R2 last wins");
    // R4: window write touches no internal location; R9: idle write data ignored.
    step(1'b1, 4'd11, 8'hFF, 4'd3, 4'd7, "R4 window write");
    step(1'b0, 4'd5, 8'hEE, 4'd5, 4'd3, "R9 idle");
    step(1'b0, 4'd0, 8'h00, 4'd5, 4'd15, "R9 after idle");
    step(1'b1, 4'd8, 8'h11, 4'd0, 4'd8, "R4 lowest window");
    step(1'b1, 4'd7, 8'h77, 4'd7, 4'd15, "R2 top local");
    step(1'b0, 4'd0, 8'h00, 4'd7, 4'd0, "R2 top local read");

    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 4'($urandom), 8'($urandom), 4'($urandom), 4'($urandom), "random");
    end

    // Mid-run reset.
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    check_all_zero("mid reset");
    @(negedge clk) rst_n = 1'b1;
    for (int n = 0; n < 200; n++) begin
      step(1'($urandom), 4'($urandom), 8'($urandom), 4'($urandom), 4'($urandom), "random2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule